// File: doc/BRIEF.md
# Multi-master I2C write engine

This block sends one write-style frame on a two-wire bus that other masters may share: a START, an address byte made of seven address bits and a direction bit, the receiver's acknowledge, one data byte, a second acknowledge and a STOP. Both lines are open-drain. The block only pulls a line low or lets it go, and it reads back the wired-AND level that the bus really carries.

Its clock follows what it sees on the bus, not what it drives. The low-time count starts when the bus clock is seen low, and the high-time count starts when the bus clock is seen high. A master that holds the clock low longer therefore stretches this block's low phase. A master that pulls the clock low early cuts its high phase short. Every bit the block sends with SDA released is checked against the bus level while SCL is high. If another master holds the line low, the block drops both lines and pulses a flag that asks the surrounding controller to fall back to slave mode.

A request is offered on a valid/ready pair. `req_ready` is high only while the engine is idle. A request is taken in the cycle where both `req_valid` and `req_ready` are high. While a frame runs, `req_ready` stays low and any offered request waits; it is neither queued nor merged. Address, direction and data need to be valid only in the accepting cycle.

Top module: `i2c_mm_tx`

## Requirements
- R1: Out of reset and whenever the engine is idle, both line pulls are inactive, `busy` is 0 and `req_ready` is 1.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high; from the next cycle `busy` is 1 and `req_ready` is 0 until the frame ends, and requests offered meanwhile start nothing.
- R3: A frame opens with a START: SDA pulled low while SCL is released, then SCL pulled low after the high count; `busy` rises together with the SDA pull.
- R4: Bits are sent MSB first: the 7 address bits, then the R/W bit, then an acknowledge clock, then the 8 data bits, then an acknowledge clock, then a STOP clock. A fully acknowledged frame therefore shows 19 rising SCL edges and exactly one STOP (SDA rising while SCL is high).
- R5: During the ninth clock of each byte SDA is released, and the bus level seen while SCL is high is the acknowledge (low = ACK). A high level gives a one-cycle `nack` pulse. After a NACK on the address byte the data byte is skipped and the STOP follows at once, giving 10 rising SCL edges.
- R6: The low phase is timed from the moment the bus SCL is seen low, and the high phase from the moment it is seen high. Raising either count by k raises the matching observed bus period by k cycles.
- R7: When another master holds SCL low beyond this block's low count, the block waits without timing high time. The following high phase has its normal length, within one cycle.
- R8: When another master pulls SCL low during this block's high phase, the high phase ends there, and the next bit goes on with correct data.
- R9: If SDA is released by the block and read low while SCL is high on an address or data bit, `arb_lost` pulses for one cycle. In the same cycle both lines are released and `busy` falls, and no STOP and no `done` follow.
- R10: A bit that the block drives low never causes `arb_lost`, even while another master also drives it low.
- R11: `done` pulses for one cycle when SDA is released after the STOP clock. `done` and `arb_lost` never pulse together.
- R12: Within a frame, the SDA pull changes only while this block pulls SCL low; the only exceptions are the START and STOP edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_count | input | CW | Low-phase length in cycles, counted from the observed SCL low (at least 4) |
| high_count | input | CW | High-phase and START hold length in cycles, counted from the observed SCL high (at least 4) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | DW-1 | Target address |
| req_rw | input | 1 | Direction bit sent after the address |
| req_data | input | DW | Data byte |
| scl_i | input | 1 | Bus SCL level (asynchronous) |
| sda_i | input | 1 | Bus SDA level (asynchronous) |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse: frame ended with STOP |
| arb_lost | output | 1 | One-cycle pulse: arbitration lost, switch to slave mode |
| nack | output | 1 | One-cycle pulse: an acknowledge slot read high |

## Verification
The bench models the bus as a wired-AND of the engine, an acknowledging receiver and a second master. Several address, direction and data patterns are sent, each with a different acknowledge pattern. Full-ACK frames check bit order and the 19-clock length. An address NACK tells the shortened 10-clock path apart from a data NACK, which still sends the data. The second master then stretches a low phase, cuts a high phase and drives SDA low: on a bit the engine sends high, which must end in arbitration loss, and on a bit the engine sends low, which must not. A rerun with larger counts shows that the bus periods track the counts one for one, measured from the observed edges.

// File: rtl/i2c_mm_tx_pkg.sv
package i2c_mm_tx_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_START,
    ENG_LOW,
    ENG_HIGH
  } eng_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_mm_tx.sv
module i2c_mm_tx
  import i2c_mm_tx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] low_count,
  input  logic [CW-1:0] high_count,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-2:0] req_addr,
  input  logic          req_rw,
  input  logic [DW-1:0] req_data,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy,
  output logic          done,
  output logic          arb_lost,
  output logic          nack
);
  localparam int SHW = 2 * DW;
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(DW);

  eng_state_e     st_q;
  logic           scl_s, sda_s;
  logic           scl_oe_q, sda_oe_q;
  logic [SHW-1:0] sh_q;
  logic [BCW-1:0] bit_q;
  logic           second_q, stop_q, seen_q, ack_q;
  logic           done_q, arb_q, nack_q;
  logic           accept, tmr_load, tmr_zero, arb_hit;
  logic [CW-1:0]  tmr_val;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  assign req_ready = (st_q == ENG_IDLE);
  assign accept    = req_valid && req_ready;

  // phase counts start from the observed bus level, never from our own drive
  always_comb begin
    tmr_load = accept
            || (st_q == ENG_LOW  && !seen_q && !scl_s)
            || (st_q == ENG_HIGH && !seen_q &&  scl_s);
    tmr_val  = (st_q == ENG_LOW) ? low_count : high_count;
  end

  i2c_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  // released bit read low while the clock is high: another master won
  assign arb_hit = (st_q == ENG_HIGH) && seen_q && !stop_q &&
                   (bit_q != ACK_SLOT) && !sda_oe_q && !sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ENG_IDLE;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      second_q <= 1'b0;
      stop_q   <= 1'b0;
      seen_q   <= 1'b0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
      arb_q    <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      nack_q <= 1'b0;
      unique case (st_q)
        ENG_IDLE: begin
          if (accept) begin
            sh_q     <= {req_addr, req_rw, req_data};
            bit_q    <= '0;
            second_q <= 1'b0;
            stop_q   <= 1'b0;
            seen_q   <= 1'b0;
            sda_oe_q <= 1'b1;
            st_q     <= ENG_START;
          end
        end
        ENG_START: begin
          if (tmr_zero) begin
            scl_oe_q <= 1'b1;
            seen_q   <= 1'b0;
            st_q     <= ENG_LOW;
          end
        end
        ENG_LOW: begin
          if (!seen_q) begin
            if (!scl_s) begin
              seen_q   <= 1'b1;
              sda_oe_q <= stop_q ? 1'b1 :
                          (bit_q == ACK_SLOT) ? 1'b0 : ~sh_q[SHW-1];
            end
          end else if (tmr_zero) begin
            scl_oe_q <= 1'b0;
            seen_q   <= 1'b0;
            st_q     <= ENG_HIGH;
          end
        end
        ENG_HIGH: begin
          if (!seen_q) begin
            if (scl_s) begin
              seen_q <= 1'b1;
              if (bit_q == ACK_SLOT && !stop_q) ack_q <= !sda_s;
            end
          end else if (arb_hit) begin
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            arb_q    <= 1'b1;
            st_q     <= ENG_IDLE;
          end else if (stop_q) begin
            if (tmr_zero) begin
              sda_oe_q <= 1'b0;
              done_q   <= 1'b1;
              st_q     <= ENG_IDLE;
            end
          end else if (tmr_zero || !scl_s) begin
            scl_oe_q <= 1'b1;
            seen_q   <= 1'b0;
            st_q     <= ENG_LOW;
            if (bit_q == ACK_SLOT) begin
              if (second_q || !ack_q) begin
                stop_q <= 1'b1;
                nack_q <= !ack_q;
              end else begin
                second_q <= 1'b1;
                bit_q    <= '0;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= sh_q << 1;
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign scl_pull = scl_oe_q;
  assign sda_pull = sda_oe_q;
  assign busy     = (st_q != ENG_IDLE);
  assign done     = done_q;
  assign arb_lost = arb_q;
  assign nack     = nack_q;
endmodule

// File: rtl/i2c_mm_tx_chk.sv
module i2c_mm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done,
  input logic arb_lost
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull && req_ready));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  assert_start_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_pull && !scl_pull));

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!scl_pull && !sda_pull && !busy));

  assert_arb_only_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !$past(sda_pull));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_arb_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, arb_lost}));

  assert_sda_in_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sda_pull != $past(sda_pull))) |-> scl_pull);
endmodule

bind i2c_mm_tx i2c_mm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
  .arb_lost(arb_lost)
);

// File: tb/i2c_mm_tx_tb_top.sv
module i2c_mm_tx_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [15:0] low_count, high_count;
  logic        req_valid, req_ready, req_rw;
  logic [6:0]  req_addr;
  logic [7:0]  req_data;
  logic        scl_pull, sda_pull, busy, done, arb_lost, nack;
  logic        m2_scl = 1'b0, m2_sda = 1'b0, slv_sda = 1'b0;
  wire         scl_bus = !(scl_pull | m2_scl);
  wire         sda_bus = !(sda_pull | m2_sda | slv_sda);

  i2c_mm_tx dut_i (
    .clk(clk), .rst_n(rst_n), .low_count(low_count), .high_count(high_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_rw(req_rw), .req_data(req_data), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
    .arb_lost(arb_lost), .nack(nack)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // bus monitor, receiver and second master, all at the falling clock edge
  int   rise_cnt = 0, starts = 0, stops = 0, done_n = 0, nack_n = 0, arb_n = 0;
  int   len = 0, stretch_left = 0;
  int   hi_len [64];
  int   lo_len [64];
  logic bitv [64];
  logic p_s = 1'b1, p_a = 1'b1;
  logic ack_a = 1'b1, ack_d = 1'b1;
  int   arb_at = 0, stretch_at = 0, stretch_len = 0, early_at = 0;
  bit   arb_sticky = 0;

  always @(negedge clk) begin
    logic s, a;
    s = scl_bus;
    a = sda_bus;
    if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) m2_scl = 1'b0;
    end
    if (done) done_n++;
    if (nack) nack_n++;
    if (arb_lost) arb_n++;
    if (s && !p_s) begin
      if (rise_cnt < 63) begin
        lo_len[rise_cnt] = len;
        rise_cnt++;
        bitv[rise_cnt] = a;
      end
      len = 0;
    end else if (!s && p_s) begin
      if (rise_cnt < 64) hi_len[rise_cnt] = len;
      len = 0;
      slv_sda = (rise_cnt == 8) ? ack_a : (rise_cnt == 17) ? ack_d : 1'b0;
      if (arb_at != 0 && rise_cnt == arb_at) m2_sda = 1'b1;
      else if (arb_at != 0 && !arb_sticky && rise_cnt == arb_at + 1) m2_sda = 1'b0;
      if (stretch_at != 0 && rise_cnt == stretch_at) begin
        m2_scl = 1'b1;
        stretch_left = stretch_len;
      end
    end else begin
      len++;
    end
    if (s && p_s && !a && p_a) begin starts++; rise_cnt = 0; end
    if (s && p_s && a && !p_a) stops++;
    if (early_at != 0 && s && p_s && rise_cnt == early_at && len == 3) begin
      m2_scl = 1'b1;
      stretch_left = 6;
    end
    p_s = s;
    p_a = a;
  end

  function automatic int cap_byte(int first);
    int v = 0;
    for (int i = 0; i < 8; i++) v = (v << 1) | int'(bitv[first + i]);
    return v;
  endfunction

  task automatic launch(logic [6:0] a, logic r, logic [7:0] d, logic aa, logic ad);
    ack_a = aa; ack_d = ad;
    starts = 0; stops = 0; done_n = 0; nack_n = 0; arb_n = 0; rise_cnt = 0;
    @(negedge clk);
    req_addr = a; req_rw = r; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (6) @(negedge clk);
  endtask

  // {addr[6:0], rw, data[7:0], receiver acks address, receiver acks data}
  localparam logic [17:0] VECS [4] = '{
    {7'h3A, 1'b0, 8'hC5, 1'b1, 1'b1},
    {7'h7F, 1'b1, 8'h00, 1'b1, 1'b1},
    {7'h01, 1'b0, 8'hFF, 1'b1, 1'b0},
    {7'h50, 1'b1, 8'h96, 1'b0, 1'b1}
  };

  int h0 = 0, l0 = 0;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_rw = 1'b0; req_data = '0;
    low_count = 16'd6; high_count = 16'd5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl_pull after reset", int'(scl_pull), 0);
    chk("R1 sda_pull after reset", int'(sda_pull), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R11 done after reset", int'(done), 0);

    for (int v = 0; v < 4; v++) begin
      logic [17:0] vec;
      vec = VECS[v];
      launch(vec[17:11], vec[10], vec[9:2], vec[1], vec[0]);
      wait_idle();
      chk("R4 address byte order", cap_byte(1), int'({vec[17:11], vec[10]}));
      chk("R5 address ack level", int'(bitv[9]), int'(!vec[1]));
      if (vec[1]) begin
        chk("R4 data byte order", cap_byte(10), int'(vec[9:2]));
        chk("R4 clock count full frame", rise_cnt, 19);
      end else begin
        chk("R5 clock count after address nack", rise_cnt, 10);
      end
      chk("R5 nack pulses", nack_n, int'(!vec[1] || !vec[0]));
      chk("R11 done pulses", done_n, 1);
      chk("R3 start count", starts, 1);
      chk("R4 stop count", stops, 1);
      chk("R9 no arbitration loss", arb_n, 0);
      if (v == 0) begin h0 = hi_len[4]; l0 = lo_len[4]; end
    end

    // R6: periods follow the counts one for one
    low_count = 16'd10; high_count = 16'd9;
    launch(7'h3A, 1'b0, 8'hC5, 1'b1, 1'b1);
    wait_idle();
    chk("R6 high period grows with high_count", hi_len[4] - h0, 4);
    chk("R6 low period grows with low_count", lo_len[4] - l0, 4);
    low_count = 16'd6; high_count = 16'd5;

    // R7: another master stretches a low phase
    stretch_at = 3; stretch_len = 40;
    launch(7'h3A, 1'b0, 8'hC5, 1'b1, 1'b1);
    wait_idle();
    stretch_at = 0;
    chk_rng("R7 stretched low period", lo_len[3], 40, 45);
    chk_rng("R7 high period after stretch", hi_len[4], h0 - 1, h0);
    chk("R7 data intact after stretch", cap_byte(10), 8'hC5);
    chk("R7 done after stretch", done_n, 1);

    // R8: another master ends a high phase early
    early_at = 5;
    launch(7'h3A, 1'b0, 8'hC5, 1'b1, 1'b1);
    wait_idle();
    early_at = 0;
    chk_rng("R8 shortened high period", hi_len[5], 0, h0 - 2);
    chk("R8 address intact", cap_byte(1), 8'h74);
    chk("R8 data intact", cap_byte(10), 8'hC5);
    chk("R8 done", done_n, 1);

    // R9: second master holds SDA low from bit 3 (engine sends 1 there)
    arb_at = 2; arb_sticky = 1;
    launch(7'h55, 1'b0, 8'h0F, 1'b1, 1'b1);
    wait_idle();
    chk("R9 arb_lost pulses", arb_n, 1);
    chk("R9 lost on third bit", rise_cnt, 3);
    chk("R9 scl released", int'(scl_pull), 0);
    chk("R9 sda released", int'(sda_pull), 0);
    chk("R9 no stop driven", stops, 0);
    chk("R11 no done after loss", done_n, 0);
    m2_sda = 1'b0; arb_at = 0; arb_sticky = 0;
    repeat (10) @(negedge clk);

    // R10: second master drives 0 on a bit the engine also drives 0
    arb_at = 1;
    launch(7'h55, 1'b0, 8'h0F, 1'b1, 1'b1);
    wait_idle();
    arb_at = 0;
    chk("R10 no loss while both drive low", arb_n, 0);
    chk("R10 frame completes", done_n, 1);
    chk("R10 address byte", cap_byte(1), 8'hAA);

    // R2: request offered while busy is ignored
    launch(7'h21, 1'b0, 8'h3C, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    chk("R2 ready low while busy", int'(req_ready), 0);
    req_addr = 7'h7E; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R2 only one start", starts, 1);
    chk("R2 first address kept", cap_byte(1), 8'h42);
    chk("R2 idle after frame", int'(busy), 0);
    chk("R1 ready again when idle", int'(req_ready), 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule